// File: doc/BRIEF.md
# Multi-Hart Timer Comparator

This block is a memory-mapped machine timer that serves a parameterised number of harts. It holds one free-running 64-bit time counter. The counter advances by one on every clock cycle in which the timebase tick-enable input is high. Each hart owns a 64-bit compare register and a level-sensitive timer interrupt output. That output stays high for as long as the hart's compare value does not exceed the counter.

Software reaches every 64-bit register over a simple register bus. The bus carries an address, a write enable, an access size of 4 or 8 bytes, and 64-bit write and read data paths. A 4-byte access moves one 32-bit half in bits 31:0, so a 32-bit processor can handle each register as a low word and a high word. An 8-byte access at the low word moves the whole value. The counter itself is writable, either whole or one half at a time.

Every access passes through a combinational decoder that classifies it. The region is `REG_NONE`, `REG_CMP` or `REG_TIME`. The part is `PART_LO`, `PART_HI` or `PART_FULL`. A write strobe is raised only for legal writes. The block has no sequencing state machine. Its only transitions are register updates: load by software, increment by the tick, hold, and the registered interrupt evaluation.

Top module: `htc_timer`

## Requirements
- R1: After reset the counter reads zero, every compare register reads all-ones, and every interrupt output is low.
- R2: The counter adds one in each cycle in which `tick` is high, carrying across the 32-bit halves. It holds its value in cycles in which `tick` is low.
- R3: A legal software write to the counter in the same cycle as a high `tick` loads the written value, and the increment is lost.
- R4: The counter low word is at `TIME_BASE` and the high word at `TIME_BASE+4`. A 4-byte write replaces only the addressed half. An 8-byte write at `TIME_BASE` replaces all 64 bits.
- R5: An 8-byte write at the high-word address of the counter or of any compare register changes nothing.
- R6: Hart n's compare register is at `CMP_BASE + 8*n`, with the low word at offset 0 and the high word at offset 4. A 4-byte write replaces only the addressed half. An 8-byte write at offset 0 replaces all 64 bits. The compare registers of other harts are untouched.
- R7: Interrupt n is high exactly when compare n is less than or equal to the counter, compared as unsigned 64-bit values. The output reflects the register values of the previous cycle, so it changes one cycle after either operand changes.
- R8: A write to the counter re-evaluates every hart's interrupt against the new value, so several interrupts may change together one cycle after the write.
- R9: Reads are combinational from the current register values. A 4-byte read of a low word returns it in bits 31:0 with bits 63:32 zero. A read of a high word, of either size, returns that word in bits 31:0 with bits 63:32 zero. An 8-byte read at a low-word address returns the full 64-bit value.
- R10: Accesses to undecoded addresses, to addresses not 4-byte aligned, or with a size other than 4 or 8 read as zero and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase tick enable; counter increments when high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_size | input | 4 | Access size in bytes (4 or 8) |
| bus_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| bus_rdata | output | 64 | Read data for the current address and size |
| irq | output | NHARTS | Per-hart timer interrupt, level sensitive |

## Verification
The hardest situation to reach is one where the counter and a compare value sit a few counts apart. Only there do the equal case, the one-cycle lag and the unsigned ordering show up. From the ports, a 64-bit counter almost never lands near an arbitrary compare value. The random phase therefore derives each written compare value from the bench's model of the counter plus a small offset, and each written counter value from a chosen hart's compare plus a small offset. Directed steps put a compare value exactly one above, exactly equal to, and far above the counter with the top bit set. A single counter write then moves all harts across their thresholds at once.

// File: rtl/htc_pkg.sv
package htc_pkg;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CMP,
        REG_TIME
    } region_e;

    typedef enum logic [1:0] {
        PART_LO,
        PART_HI,
        PART_FULL
    } part_e;

    // Fold new write data into an existing 64-bit register according to the part addressed.
    function automatic logic [63:0] fold_write(input logic [63:0] old_val,
                                               input logic [63:0] wdata,
                                               input part_e      part);
        logic [63:0] res;
        unique case (part)
            PART_LO:   res = {old_val[63:32], wdata[31:0]};
            PART_HI:   res = {wdata[31:0], old_val[31:0]};
            PART_FULL: res = wdata;
            default:   res = old_val;
        endcase
        return res;
    endfunction

    // Present a 64-bit register on the read path according to the part addressed.
    function automatic logic [63:0] read_view(input logic [63:0] val,
                                              input part_e      part);
        logic [63:0] res;
        unique case (part)
            PART_LO:   res = {32'h0, val[31:0]};
            PART_HI:   res = {32'h0, val[63:32]};
            PART_FULL: res = val;
            default:   res = '0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/htc_decode.sv
module htc_decode
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NHARTS    = 4,
    parameter int CMP_BASE  = 'h0000,
    parameter int TIME_BASE = 'h7FF8,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic              we,
    output region_e           region,
    output part_e             part,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_en
);

    localparam logic [ADDR_W-1:0] CMP_B    = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NHARTS);
    localparam logic [ADDR_W-1:0] TIME_LO  = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TIME_HI  = ADDR_W'(TIME_BASE + 4);

    logic [ADDR_W-1:0] rel;
    logic              size_ok;
    logic              wide;
    logic              hi_word;

    always_comb begin
        rel     = addr - CMP_B;
        size_ok = (size == 4'd4) || (size == 4'd8);
        wide    = (size == 4'd8);
        region  = REG_NONE;
        hi_word = 1'b0;
        idx     = rel[3 +: IDX_W];

        if (size_ok && (addr[1:0] == 2'b00)) begin
            if ((addr >= CMP_B) && (rel < CMP_SPAN)) begin
                region  = REG_CMP;
                hi_word = rel[2];
            end else if (addr == TIME_LO) begin
                region  = REG_TIME;
                hi_word = 1'b0;
            end else if (addr == TIME_HI) begin
                region  = REG_TIME;
                hi_word = 1'b1;
            end
        end

        unique case ({hi_word, wide})
            2'b00:   part = PART_LO;
            2'b01:   part = PART_FULL;
            2'b10:   part = PART_HI;
            default: part = PART_HI;
        endcase

        // A wide write starting at a high word is illegal and dropped.
        wr_en = we && (region != REG_NONE) && !(hi_word && wide);
    end

endmodule

// File: rtl/htc_counter.sv
module htc_counter
    import htc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        load,
    input  part_e       part,
    input  logic [63:0] wdata,
    output logic [63:0] time_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (load) begin
            time_q <= fold_write(time_q, wdata, part);
        end else if (tick) begin
            time_q <= time_q + 64'd1;
        end
    end

endmodule

// File: rtl/htc_cmp_bank.sv
module htc_cmp_bank
    import htc_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [IDX_W-1:0]        idx,
    input  part_e                   part,
    input  logic [63:0]             wdata,
    input  logic [63:0]             time_q,
    output logic [NHARTS-1:0][63:0] cmp_q,
    output logic [NHARTS-1:0]       irq
);

    for (genvar h = 0; h < NHARTS; h++) begin : g_hart
        logic sel;
        assign sel = load && (idx == IDX_W'(h));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[h] <= '1;
            end else if (sel) begin
                cmp_q[h] <= fold_write(cmp_q[h], wdata, part);
            end
        end

        // Registered unsigned comparison against the shared counter.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq[h] <= 1'b0;
            end else begin
                irq[h] <= (cmp_q[h] <= time_q);
            end
        end
    end

endmodule

// File: rtl/htc_timer.sv
module htc_timer
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NHARTS    = 4,
    parameter int CMP_BASE  = 'h0000,
    parameter int TIME_BASE = 'h7FF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic [NHARTS-1:0] irq
);

    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1;

    region_e                 region;
    part_e                   part;
    logic [IDX_W-1:0]        idx;
    logic                    wr_en;
    logic [63:0]             time_q;
    logic [NHARTS-1:0][63:0] cmp_q;
    logic [63:0]             cmp_sel;

    htc_decode #(
        .ADDR_W   (ADDR_W),
        .NHARTS   (NHARTS),
        .CMP_BASE (CMP_BASE),
        .TIME_BASE(TIME_BASE),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr  (bus_addr),
        .size  (bus_size),
        .we    (bus_we),
        .region(region),
        .part  (part),
        .idx   (idx),
        .wr_en (wr_en)
    );

    htc_counter u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (wr_en && (region == REG_TIME)),
        .part  (part),
        .wdata (bus_wdata),
        .time_q(time_q)
    );

    htc_cmp_bank #(
        .NHARTS(NHARTS),
        .IDX_W (IDX_W)
    ) u_cmp_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_en && (region == REG_CMP)),
        .idx   (idx),
        .part  (part),
        .wdata (bus_wdata),
        .time_q(time_q),
        .cmp_q (cmp_q),
        .irq   (irq)
    );

    always_comb begin
        cmp_sel = '0;
        for (int h = 0; h < NHARTS; h++) begin
            if (idx == IDX_W'(h)) cmp_sel = cmp_q[h];
        end
    end

    always_comb begin
        unique case (region)
            REG_CMP:  bus_rdata = read_view(cmp_sel, part);
            REG_TIME: bus_rdata = read_view(time_q, part);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/htc_timer_checker.sv
module htc_timer_checker
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NHARTS    = 4,
    parameter int TIME_BASE = 'h7FF8,
    parameter int IDX_W     = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [3:0]              bus_size,
    input logic [63:0]             bus_wdata,
    input logic [NHARTS-1:0]       irq,
    input logic [63:0]             time_q,
    input logic [NHARTS-1:0][63:0] cmp_q,
    input region_e                 region,
    input part_e                   part,
    input logic [IDX_W-1:0]        idx,
    input logic                    wr_en
);

    logic time_load;
    assign time_load = wr_en && (region == REG_TIME);

    // R1: leaving reset, the counter is zero and no interrupt is raised.
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (time_q == 64'd0) && (irq == '0));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_load && tick) |=> time_q == $past(time_q) + 64'd1);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_load && !tick) |=> $stable(time_q));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (time_load && part == PART_FULL) |=> time_q == $past(bus_wdata));

    assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (time_load && part == PART_LO) |=> time_q[63:32] == $past(time_q[63:32]));

    assert_wide_hi_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_size == 4'd8 && bus_addr == ADDR_W'(TIME_BASE + 4) && !tick)
        |=> $stable(time_q));

    for (genvar h = 0; h < NHARTS; h++) begin : g_chk
        assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && region == REG_CMP && idx == IDX_W'(h) && part == PART_HI)
            |=> cmp_q[h][31:0] == $past(cmp_q[h][31:0]));

        assert_other_hart_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && region == REG_CMP && idx == IDX_W'(h)) |=> $stable(cmp_q[h]));

        assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[h] == ($past(cmp_q[h]) <= $past(time_q)));
    end

endmodule

bind htc_timer htc_timer_checker #(
    .ADDR_W   (ADDR_W),
    .NHARTS   (NHARTS),
    .TIME_BASE(TIME_BASE),
    .IDX_W    (IDX_W)
) u_htc_timer_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .time_q   (time_q),
    .cmp_q    (cmp_q),
    .region   (region),
    .part     (part),
    .idx      (idx),
    .wr_en    (wr_en)
);

// File: tb/htc_timer_bench.sv
module htc_timer_bench;

    localparam int PERIOD = 10;
    localparam int NH     = 4;
    localparam int AW     = 16;
    localparam int TB     = 'h7FF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_size = 4'd4;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [NH-1:0] irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [63:0]   m_time;
    logic [63:0]   m_cmp [NH];
    logic [NH-1:0] exp_irq;

    always #(PERIOD/2) clk = ~clk;

    htc_timer #(
        .ADDR_W   (AW),
        .NHARTS   (NH),
        .CMP_BASE ('h0000),
        .TIME_BASE(TB)
    ) u_htc_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_read(input logic [AW-1:0] a, input logic [3:0] sz);
        logic [63:0] v;
        logic        hi;
        if (!(sz == 4'd4 || sz == 4'd8) || a[1:0] != 2'b00) return '0;
        if (int'(a) < 8 * NH) begin
            v  = m_cmp[int'(a) >> 3];
            hi = a[2];
        end else if (int'(a) == TB) begin
            v  = m_time;
            hi = 1'b0;
        end else if (int'(a) == TB + 4) begin
            v  = m_time;
            hi = 1'b1;
        end else begin
            return '0;
        end
        if (hi) return {32'h0, v[63:32]};
        if (sz == 4'd8) return v;
        return {32'h0, v[31:0]};
    endfunction

    // One clock: drive at the negative edge, update the model at the positive edge.
    task automatic step(input logic we, input logic [AW-1:0] a, input logic [3:0] sz,
                        input logic [63:0] d, input logic tk);
        bit loaded;
        bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d; tick = tk;
        @(posedge clk);
        for (int h = 0; h < NH; h++) exp_irq[h] = (m_cmp[h] <= m_time);
        loaded = 1'b0;
        if (we && (sz == 4'd4 || sz == 4'd8) && a[1:0] == 2'b00) begin
            if (int'(a) < 8 * NH) begin
                if (!a[2])
                    m_cmp[int'(a) >> 3] = (sz == 4'd8) ? d : {m_cmp[int'(a) >> 3][63:32], d[31:0]};
                else if (sz == 4'd4)
                    m_cmp[int'(a) >> 3] = {d[31:0], m_cmp[int'(a) >> 3][31:0]};
            end else if (int'(a) == TB) begin
                m_time = (sz == 4'd8) ? d : {m_time[63:32], d[31:0]};
                loaded = 1'b1;
            end else if (int'(a) == TB + 4 && sz == 4'd4) begin
                m_time = {d[31:0], m_time[31:0]};
                loaded = 1'b1;
            end
        end
        if (!loaded && tk) m_time = m_time + 64'd1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0; bus_size = 4'd4;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [3:0] sz,
                      input logic [63:0] exp);
        bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        chk(req, bus_rdata, exp);
        bus_size = 4'd4;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 4'd4, '0, 1'b0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_time  = '0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;
        exp_irq = '0;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 irq", 64'(irq), 64'h0);
        rd("R1 time", AW'(TB), 4'd8, 64'h0);
        rd("R1 cmp0", 16'h0000, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R1 cmp3 hi", 16'h001C, 4'd4, 64'hFFFF_FFFF);

        // R2: tick increments and holds
        for (int i = 0; i < 5; i++) step(1'b0, '0, 4'd4, '0, 1'b1);
        rd("R2 count5", AW'(TB), 4'd8, 64'd5);
        idle(3);
        rd("R2 hold", AW'(TB), 4'd8, 64'd5);

        // R3: write beats tick
        step(1'b1, AW'(TB), 4'd8, 64'h1_FFFF_FFFE, 1'b1);
        rd("R3 load", AW'(TB), 4'd8, 64'h1_FFFF_FFFE);
        step(1'b0, '0, 4'd4, '0, 1'b1);
        step(1'b0, '0, 4'd4, '0, 1'b1);
        rd("R2 carry", AW'(TB), 4'd8, 64'h2_0000_0000);

        // R4: half writes of the counter
        step(1'b1, AW'(TB), 4'd4, 64'hFFFF_FFFF_0000_0010, 1'b0);
        rd("R4 lo", AW'(TB), 4'd8, 64'h2_0000_0010);
        step(1'b1, AW'(TB + 4), 4'd4, 64'h0000_00AB, 1'b0);
        rd("R4 hi", AW'(TB), 4'd8, 64'hAB_0000_0010);
        rd("R9 wide at hi", AW'(TB + 4), 4'd8, 64'hAB);
        rd("R9 narrow lo", AW'(TB), 4'd4, 64'h10);

        // R5: wide writes at a high word are dropped
        step(1'b1, AW'(TB + 4), 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
        rd("R5 time", AW'(TB), 4'd8, 64'hAB_0000_0010);
        step(1'b1, 16'h000C, 4'd8, 64'h0, 1'b0);
        rd("R5 cmp1", 16'h0008, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);

        // R6: compare half writes and per-hart placement
        step(1'b1, 16'h0010, 4'd4, 64'h1111_1111_0000_0055, 1'b0);
        rd("R6 cmp2 lo", 16'h0010, 4'd8, 64'hFFFF_FFFF_0000_0055);
        step(1'b1, 16'h0014, 4'd4, 64'h0, 1'b0);
        rd("R6 cmp2 hi", 16'h0010, 4'd8, 64'h55);
        rd("R6 cmp1 untouched", 16'h0008, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R6 cmp3 untouched", 16'h0018, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);

        // R7: threshold and one-cycle lag
        step(1'b1, 16'h0000, 4'd8, 64'hAB_0000_0011, 1'b0);
        idle(1);
        chk("R7 above", 64'(irq[0]), 64'd0);
        step(1'b1, AW'(TB), 4'd4, 64'h11, 1'b0);
        chk("R7 lag", 64'(irq[0]), 64'd0);
        idle(1);
        chk("R7 equal", 64'(irq[0]), 64'd1);
        step(1'b1, 16'h0000, 4'd8, 64'h8000_0000_0000_0000, 1'b0);
        idle(1);
        chk("R7 unsigned", 64'(irq[0]), 64'd0);

        // R8: one counter write moves all harts together
        step(1'b1, 16'h0000, 4'd8, 64'h1000, 1'b0);
        step(1'b1, 16'h0008, 4'd8, 64'h1000, 1'b0);
        step(1'b1, 16'h0018, 4'd8, 64'h1000, 1'b0);
        step(1'b1, AW'(TB), 4'd8, 64'h0, 1'b0);
        idle(1);
        chk("R8 all low", 64'(irq), 64'h0);
        step(1'b1, AW'(TB), 4'd8, 64'h1000, 1'b0);
        idle(1);
        chk("R8 all high", 64'(irq), 64'hF);

        // R10: undecoded, misaligned and bad-size accesses
        rd("R10 beyond harts", 16'h0040, 4'd4, 64'h0);
        rd("R10 misaligned", 16'h0002, 4'd4, 64'h0);
        rd("R10 bad size", AW'(TB), 4'd2, 64'h0);
        step(1'b1, 16'h7FF0, 4'd8, 64'h1234, 1'b0);
        rd("R10 time kept", AW'(TB), 4'd8, 64'h1000);
        step(1'b1, 16'h0000, 4'd2, 64'h7777, 1'b0);
        step(1'b1, 16'h0001, 4'd4, 64'h7777, 1'b0);
        rd("R10 cmp0 kept", 16'h0000, 4'd8, 64'h1000);

        // Random phase, values kept near each other so thresholds are crossed
        for (int it = 0; it < 600; it++) begin
            int          op;
            int          hh;
            logic [63:0] d;
            logic        tk;
            logic [AW-1:0] ra;
            op = int'($urandom % 8);
            hh = int'($urandom % NH);
            tk = 1'($urandom % 2);
            d  = {$urandom, $urandom};
            unique case (op)
                0: step(1'b1, AW'(8 * hh), 4'd8, m_time + 64'(int'($urandom % 16) - 8), tk);
                1: step(1'b1, AW'(8 * hh), 4'd4, d, tk);
                2: step(1'b1, AW'(8 * hh + 4), 4'd4, {32'h0, m_time[63:32]}, tk);
                3: step(1'b1, AW'(TB), 4'd8, m_cmp[hh] + 64'(int'($urandom % 8) - 4), tk);
                4: step(1'b1, ($urandom % 2) ? AW'(TB) : AW'(TB + 4), 4'd4, d, tk);
                5: step(1'b1, ($urandom % 2) ? AW'(TB + 4) : AW'(8 * hh + 4), 4'd8, d, tk);
                6: step(1'b1, AW'(16'h0100 + 4 * ($urandom % 8)), 4'd8, d, tk);
                default: step(1'b0, '0, 4'd4, '0, tk);
            endcase
            chk("R7 R8 random irq", 64'(irq), 64'(exp_irq));
            ra = ($urandom % 3 == 0) ? AW'(TB + 4 * ($urandom % 2)) : AW'(4 * ($urandom % (2 * NH + 2)));
            begin
                logic [3:0] rsz;
                rsz = ($urandom % 2) ? 4'd8 : 4'd4;
                rd("R9 random read", ra, rsz, exp_read(ra, rsz));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule